// File: doc/BRIEF.md
# UART Receive Status and Error Flags

This block is the receive-side status logic of a register-mapped UART. The RX deserializer hands it one finished character at a time, as a one-cycle strobe with the data bits, the sampled parity bit and the sampled stop bit. The block trims the character to the programmed word length and stores it in a receive buffer register. It checks the character against the line settings, keeps the data-ready, overrun, parity, framing and break flags, and raises a line-status interrupt request.

A CPU bus drives two read strobes, one for the receive buffer and one for the status byte. It also supplies the line-status interrupt enable. Each register clears its own flags when it is read. A buffer read clears only data-ready. A status read clears only the four error flags. An error that arrives in the same cycle as a status read is kept. The transmit-side status bits belong to another block and read as zero here.

Top module: `uart_rx_status`

## Requirements
- R1: `lsr[0]` (data ready) is 1 in the cycle after `rx_valid` and stays 1 until a `rd_rbr` cycle with no `rx_valid`. A load in the same cycle as `rd_rbr` keeps it 1.
- R2: `lsr[1]` (overrun) sets when `rx_valid` arrives while data ready is 1 and `rd_rbr` is 0. `rbr_data` then holds the new character.
- R3: When `par_en` is 1, `lsr[2]` (parity error) sets on a load if the received parity is wrong. With `par_even`=1 the active data bits plus the parity bit must hold an even count of ones. With `par_even`=0 the count must be odd. When `par_en` is 0, no parity error is flagged.
- R4: `lsr[3]` (framing error) sets on a load whose `rx_stop_bit` is 0.
- R5: `lsr[4]` (break) sets on a load in which every line bit is 0: the active data bits, the stop bit, and the parity bit when `par_en` is 1. A break also sets the framing error.
- R6: `wlen_sel` values 0, 1, 2 and 3 select DATA_W-3, DATA_W-2, DATA_W-1 and DATA_W active data bits. Inactive bits are stored and read as 0 and take no part in the parity or break checks.
- R7: A `rd_lsr` cycle with no new error clears `lsr[4:1]` on the next cycle. It leaves `lsr[0]` unchanged.
- R8: When an error flag is set in the same cycle as `rd_lsr`, the set wins and the flag reads 1 afterwards.
- R9: `lsi_irq` is 1 exactly while `ier_lsi` is 1 and any of `lsr[4:1]` is 1.
- R10: `lsr[7:5]` always read 0. Synchronous reset clears every flag, `rbr_data` and `lsi_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe: a finished character is on the rx inputs |
| rx_data | input | DATA_W | Received data bits, LSB first on the line |
| rx_par_bit | input | 1 | Sampled parity bit |
| rx_stop_bit | input | 1 | Sampled stop bit |
| par_en | input | 1 | Parity checking enabled |
| par_even | input | 1 | 1 selects even parity, 0 selects odd parity |
| wlen_sel | input | 2 | Word length select (R6) |
| rd_rbr | input | 1 | CPU read strobe of the receive buffer |
| rd_lsr | input | 1 | CPU read strobe of the status byte |
| ier_lsi | input | 1 | Line-status interrupt enable |
| rbr_data | output | DATA_W | Receive buffer contents |
| lsr | output | 8 | Status byte: bit0 ready, bit1 overrun, bit2 parity, bit3 framing, bit4 break, bits 7:5 zero |
| lsi_irq | output | 1 | Line-status interrupt request |

## Verification
The assertions check on every cycle that a load sets data ready, that an unread load sets overrun, and that a status read clears the error flags while leaving data ready alone. They also check that an error set wins over a same-cycle status read, that a break always comes with a framing error, and that the interrupt holds until a status read or a disable. Only the bench's scenarios can show that the parity check follows the even/odd selection and the word length, that inactive data bits read as zero, and that the stored character is the one expected. A model-driven pseudo-random run also covers combinations of loads and reads in the same cycle.

// File: rtl/uart_rxs_pkg.sv
package uart_rxs_pkg;

    // Widest character the helper functions support
    localparam int MAX_W = 16;

    // Status byte bit positions (decoded by the CPU side)
    localparam int LSR_W  = 8;
    localparam int LSR_DR = 0;
    localparam int LSR_OE = 1;
    localparam int LSR_PE = 2;
    localparam int LSR_FE = 3;
    localparam int LSR_BI = 4;

    // Per-character error indications, order fixed for vector casts
    typedef struct packed {
        logic perr;
        logic ferr;
        logic brk;
    } rx_err_t;

    localparam int ERR_W = $bits(rx_err_t);

    // Mask with the low nbits set
    function automatic logic [MAX_W-1:0] len_mask(input int unsigned nbits);
        logic [MAX_W-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_W; i++) begin
            if (i < nbits) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/rxs_frame_check.sv
module rxs_frame_check
    import uart_rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_bit,
    input  logic              rx_stop_bit,
    input  logic              par_en,
    input  logic              par_even,
    input  logic [1:0]        wlen_sel,
    output logic [DATA_W-1:0] data_m,
    output rx_err_t           err
);
    localparam int MIN_W = DATA_W - 3;

    logic [MAX_W-1:0] wide;
    logic [MAX_W-1:0] mask;
    logic             ones_odd;

    always_comb begin
        wide     = MAX_W'(rx_data);
        mask     = len_mask(MIN_W + int'(wlen_sel));
        data_m   = DATA_W'(wide & mask);
        ones_odd = ^{data_m, rx_par_bit};
        // even selection wants an even count; odd selection wants odd
        err.perr = par_en & (ones_odd ^ ~par_even);
        err.ferr = ~rx_stop_bit;
        err.brk  = (data_m == '0) & ~rx_stop_bit & (~par_en | ~rx_par_bit);
    end

endmodule

// File: rtl/rxs_buffer.sv
module rxs_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_rbr,
    input  logic              rd_lsr,
    output logic [DATA_W-1:0] dout,
    output logic              ready,
    output logic              ovr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout  <= '0;
            ready <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (load) dout <= din;

            if (load)        ready <= 1'b1;
            else if (rd_rbr) ready <= 1'b0;

            if (load && ready && !rd_rbr) ovr <= 1'b1;
            else if (rd_lsr)              ovr <= 1'b0;
        end
    end

    // R1
    ready_set_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> ready);
    // R1
    ready_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_rbr && !load) |=> !ready);
    // R2
    ovr_set_chk: assert property (@(posedge clk) disable iff (rst)
        (load && ready && !rd_rbr) |=> ovr);
    // R7
    ready_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && ready && !rd_rbr) |=> ready);

endmodule

// File: rtl/rxs_err_flags.sv
module rxs_err_flags
    import uart_rxs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  rx_err_t err_i,
    input  logic    rd_lsr,
    output rx_err_t flags_o
);
    logic [ERR_W-1:0] set_v;
    logic [ERR_W-1:0] flag_q;

    assign set_v   = load ? ERR_W'(err_i) : '0;
    assign flags_o = rx_err_t'(flag_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            for (int i = 0; i < ERR_W; i++) begin
                if (set_v[i])    flag_q[i] <= 1'b1;
                else if (rd_lsr) flag_q[i] <= 1'b0;
            end
        end
    end

    // R7
    err_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !load) |=> (flags_o == '0));
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (load && err_i.ferr && rd_lsr) |=> flags_o.ferr);
    // R5
    brk_fe_chk: assert property (@(posedge clk) disable iff (rst)
        (load && err_i.brk) |=> (flags_o.brk && flags_o.ferr));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rxs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_par_bit,
    input  logic              rx_stop_bit,
    input  logic              par_en,
    input  logic              par_even,
    input  logic [1:0]        wlen_sel,
    input  logic              rd_rbr,
    input  logic              rd_lsr,
    input  logic              ier_lsi,
    output logic [DATA_W-1:0] rbr_data,
    output logic [LSR_W-1:0]  lsr,
    output logic              lsi_irq
);
    logic [DATA_W-1:0] data_m;
    rx_err_t           err_now;
    rx_err_t           flags;
    logic              ready;
    logic              ovr;

    rxs_frame_check #(.DATA_W(DATA_W)) u_check (
        .rx_data     (rx_data),
        .rx_par_bit  (rx_par_bit),
        .rx_stop_bit (rx_stop_bit),
        .par_en      (par_en),
        .par_even    (par_even),
        .wlen_sel    (wlen_sel),
        .data_m      (data_m),
        .err         (err_now)
    );

    rxs_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .load   (rx_valid),
        .din    (data_m),
        .rd_rbr (rd_rbr),
        .rd_lsr (rd_lsr),
        .dout   (rbr_data),
        .ready  (ready),
        .ovr    (ovr)
    );

    rxs_err_flags u_err (
        .clk     (clk),
        .rst     (rst),
        .load    (rx_valid),
        .err_i   (err_now),
        .rd_lsr  (rd_lsr),
        .flags_o (flags)
    );

    always_comb begin
        lsr         = '0;
        lsr[LSR_DR] = ready;
        lsr[LSR_OE] = ovr;
        lsr[LSR_PE] = flags.perr;
        lsr[LSR_FE] = flags.ferr;
        lsr[LSR_BI] = flags.brk;
    end

    assign lsi_irq = ier_lsi & (ovr | flags.perr | flags.ferr | flags.brk);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lsi_irq && !rd_lsr) |=> (lsi_irq || !ier_lsi));
    // R2
    ovr_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && ready && !rd_rbr && ier_lsi) |=> (lsi_irq || !ier_lsi));

endmodule

// File: tb/uart_rx_status_tb.sv
`timescale 1ns/1ps
module uart_rx_status_tb;

    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rx_valid = 1'b0;
    logic [DATA_W-1:0] rx_data = '0;
    logic              rx_par_bit = 1'b0;
    logic              rx_stop_bit = 1'b1;
    logic              par_en = 1'b0;
    logic              par_even = 1'b0;
    logic [1:0]        wlen_sel = 2'd3;
    logic              rd_rbr = 1'b0;
    logic              rd_lsr = 1'b0;
    logic              ier_lsi = 1'b0;
    logic [DATA_W-1:0] rbr_data;
    logic [7:0]        lsr;
    logic              lsi_irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    uart_rx_status #(.DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_par_bit(rx_par_bit), .rx_stop_bit(rx_stop_bit), .par_en(par_en),
        .par_even(par_even), .wlen_sel(wlen_sel), .rd_rbr(rd_rbr),
        .rd_lsr(rd_lsr), .ier_lsi(ier_lsi), .rbr_data(rbr_data),
        .lsr(lsr), .lsi_irq(lsi_irq)
    );

    typedef struct packed {
        logic       v;
        logic [7:0] d;
        logic       par;
        logic       stp;
        logic       pen;
        logic       pev;
        logic [1:0] wl;
        logic       rdr;
        logic       rdl;
        logic       ier;
        logic [4:0] elsr;
        logic       eirq;
        logic [7:0] erbr;
        logic [3:0] rq;
    } vec_t;

    // Each row: stimulus for one edge, expected state after it
    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 5'b00001, 1'b0, 8'hA5, 4'd1}, // R1 load
        '{1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 5'b00011, 1'b1, 8'h3C, 4'd2}, // R2 overrun
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 5'b00001, 1'b0, 8'h3C, 4'd7}, // R7 status read
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 5'b00000, 1'b0, 8'h3C, 4'd1}, // R1 buffer read
        '{1'b1, 8'h07, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 1'b1, 5'b00101, 1'b1, 8'h07, 4'd3}, // R3 even wrong
        '{1'b1, 8'h07, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 1'b1, 5'b00101, 1'b1, 8'h07, 4'd3}, // R3 odd ok, R1 same-cycle
        '{1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b1, 1'b1, 5'b01011, 1'b1, 8'h55, 4'd8}, // R8 set wins
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b0, 5'b01011, 1'b0, 8'h55, 4'd9}, // R9 disabled
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1, 5'b00000, 1'b0, 8'h55, 4'd7}, // R7 both reads
        '{1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1, 5'b11001, 1'b1, 8'h00, 4'd5}, // R5 break
        '{1'b1, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 1'b1, 5'b00001, 1'b0, 8'h1F, 4'd6}, // R6 5-bit word
        '{1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 5'b01001, 1'b1, 8'h00, 4'd4}, // R4 framing only
        '{1'b1, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 1'b1, 5'b00001, 1'b0, 8'h7F, 4'd6}  // R6 7-bit parity
    };

    task automatic check(input logic [7:0] e_lsr, input logic e_irq,
                         input logic [7:0] e_rbr, input string tag);
        n_vec++;
        if (lsr !== e_lsr || lsi_irq !== e_irq || rbr_data !== e_rbr) begin
            n_bad++;
            $display("FAIL %s: lsr=%h irq=%b rbr=%h, expected lsr=%h irq=%b rbr=%h",
                     tag, lsr, lsi_irq, rbr_data, e_lsr, e_irq, e_rbr);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] d, input logic par,
                         input logic stp, input logic pen, input logic pev,
                         input logic [1:0] wl, input logic rdr, input logic rdl,
                         input logic ier);
        rx_valid = v; rx_data = d; rx_par_bit = par; rx_stop_bit = stp;
        par_en = pen; par_even = pev; wlen_sel = wl;
        rd_rbr = rdr; rd_lsr = rdl; ier_lsi = ier;
    endtask

    // Reference model state
    logic [7:0] m_rbr;
    logic m_dr, m_oe, m_pe, m_fe, m_bi;

    task automatic model_step();
        logic [7:0] mask, dm;
        logic pe_n, fe_n, bi_n;
        mask = 8'hFF >> (2'd3 - wlen_sel);
        dm   = rx_data & mask;
        pe_n = par_en & ((^{dm, rx_par_bit}) ^ ~par_even);
        fe_n = ~rx_stop_bit;
        bi_n = (dm == 8'h00) & ~rx_stop_bit & (~par_en | ~rx_par_bit);
        if (rx_valid && m_dr && !rd_rbr) m_oe = 1'b1; else if (rd_lsr) m_oe = 1'b0;
        if (rx_valid && pe_n) m_pe = 1'b1; else if (rd_lsr) m_pe = 1'b0;
        if (rx_valid && fe_n) m_fe = 1'b1; else if (rd_lsr) m_fe = 1'b0;
        if (rx_valid && bi_n) m_bi = 1'b1; else if (rd_lsr) m_bi = 1'b0;
        if (rx_valid) m_dr = 1'b1; else if (rd_rbr) m_dr = 1'b0;
        if (rx_valid) m_rbr = dm;
    endtask

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R10 reset state
        check(8'h00, 1'b0, 8'h00, "R10 reset");
        rst = 1'b0;

        foreach (TBL[i]) begin
            drive(TBL[i].v, TBL[i].d, TBL[i].par, TBL[i].stp, TBL[i].pen,
                  TBL[i].pev, TBL[i].wl, TBL[i].rdr, TBL[i].rdl, TBL[i].ier);
            @(posedge clk);
            @(negedge clk);
            // R10: bits 7:5 expected zero in every row
            check({3'b000, TBL[i].elsr}, TBL[i].eirq, TBL[i].erbr,
                  $sformatf("R%0d row %0d", TBL[i].rq, i));
        end

        // R10 reset while flags are set and a character arrives
        drive(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(8'h00, 1'b0, 8'h00, "R10 reset mid-run");
        rst = 1'b0;
        drive(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1);

        // Model-compared pseudo-random run (R1..R9)
        m_rbr = '0; m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0;
        lfsr = 16'hACE1;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0], {lfsr[9:6], lfsr[13:10]} & {8{lfsr[5]}},
                  lfsr[1], lfsr[2] | lfsr[3], lfsr[4], lfsr[8],
                  lfsr[15:14], lfsr[6] & lfsr[7], lfsr[9] & lfsr[11],
                  ~(lfsr[12] & lfsr[13]));
            model_step();
            @(posedge clk);
            @(negedge clk);
            check({3'b000, m_bi, m_fe, m_pe, m_oe, m_dr},
                  ier_lsi & (m_oe | m_pe | m_fe | m_bi), m_rbr,
                  "R1-model R2 R3 R4 R5 R6 R7 R8 R9");
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule